// File: doc/BRIEF.md
# Shortened Reed-Solomon (204,188) Systematic Encoder

This block turns a stream of 188-byte messages into 204-byte codewords of a Reed-Solomon code over GF(2^8). It is shortened from the (255,239) code, so each codeword carries 16 check bytes and lets a decoder downstream correct up to 8 corrupted bytes, or fill in up to 16 bytes known to be missing. The message bytes leave the block unchanged and in their original order. The 16 check bytes follow them, and are computed by a polynomial-division shift register whose taps are constant field multipliers.

Both sides of the block use valid/ready handshakes. On the input side a start-of-packet flag marks the first message byte. On the output side an end-of-packet flag marks the last check byte. While message bytes are flowing, the input is combinationally connected to the output, so backpressure from the sink reaches the source directly. While check bytes are flowing, the input is held off, so the next packet waits rather than being lost.

Top module: `rs204_encoder`

## Requirements
- R1: After reset, with no input offered, `out_valid` and `out_eop` are low and `in_ready` is high.
- R2: The first 188 output bytes of each codeword equal the 188 accepted message bytes, unchanged and in the same order.
- R3: Output bytes 189 to 204 are the remainder of m(x)·x^16 divided by g(x), emitted from the highest-degree coefficient down. Here g(x) is the product of (x + α^i) for i = 0..15, α = 0x02, and the field polynomial is x^8+x^4+x^3+x^2+1 (0x11D). As a consequence, the 204-byte codeword, read with its first byte as the x^203 coefficient, evaluates to zero at every root α^0..α^15.
- R4: `out_eop` is high with the 204th byte of a codeword and with no other byte.
- R5: `in_ready` is low for as long as check bytes are being offered. A next packet presented early is stalled and then encoded in full.
- R6: While a check byte is offered and `out_ready` is low, `out_valid` stays high and `out_data` holds its value. No byte is skipped or repeated.
- R7: At a packet boundary, an offered byte without `in_sop` is consumed and discarded, and produces no output. Inside a message, `in_sop` has no effect and the byte is treated as data.
- R8: The division register starts from zero for every packet, so a codeword depends only on its own message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Encoder takes the offered byte this cycle |
| in_sop | input | 1 | Offered byte is the first of a message |
| in_data | input | 8 | Message byte |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Sink takes the offered byte this cycle |
| out_data | output | 8 | Codeword byte |
| out_eop | output | 1 | Offered byte is the last of a codeword |

## Verification
The hardest situation to reach from the ports is the overlap of a check-byte phase with a sink that stalls and a source that is already presenting the next packet's first byte. To get there, the bench runs its source and sink as independent processes. The source never waits for a codeword to drain, and the sink applies a periodic ready pattern, so stalls land inside the check-byte phase. Every message position is also swept with a single nonzero byte, which exercises each generator tap. Each codeword is then judged twice: once against a long division computed in the bench, and once by evaluating its syndromes at all 16 roots.

// File: rtl/rs204_pkg.sv
// Shared field arithmetic for the RS encoder.
// Assumes GF(2^8) with the field polynomial 0x11D and a primitive element of 0x02.
package rs204_pkg;
    localparam int              SYM_W      = 8;
    localparam logic [SYM_W:0]  FIELD_POLY = 9'h11D;
    localparam int              MAX_PAR    = 32;

    typedef logic [SYM_W-1:0] sym_t;

    // Shift-and-add multiply with reduction modulo the field polynomial.
    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t acc;
        sym_t aa;
        acc = '0;
        aa  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = aa[SYM_W-1] ? (sym_t'(aa << 1) ^ FIELD_POLY[SYM_W-1:0]) : sym_t'(aa << 1);
        end
        return acc;
    endfunction

    // Power of the primitive element.
    function automatic sym_t gf_alpha_pow(input int e);
        sym_t r;
        r = sym_t'(1);
        for (int i = 0; i < e; i++) r = gf_mul(r, sym_t'(2));
        return r;
    endfunction

    // Coefficient idx of the monic generator: product of (x + alpha^(first_root+i)).
    function automatic sym_t gen_coef(input int idx, input int npar, input int first_root);
        sym_t g [0:MAX_PAR];
        sym_t root;
        for (int k = 0; k <= MAX_PAR; k++) g[k] = '0;
        g[0] = sym_t'(1);
        for (int i = 0; i < MAX_PAR; i++) begin
            if (i < npar) begin
                root = gf_alpha_pow(first_root + i);
                for (int k = MAX_PAR; k >= 1; k--) begin
                    if (k <= i + 1) g[k] = g[k-1] ^ gf_mul(g[k], root);
                end
                g[0] = gf_mul(g[0], root);
            end
        end
        return g[idx];
    endfunction
endpackage

// File: rtl/rs_gf_cmul.sv
// Multiplies a symbol by a fixed field constant.
// Assumes COEF is known at elaboration, so the logic reduces to an XOR network.
module rs_gf_cmul
    import rs204_pkg::*;
#(
    parameter sym_t COEF = '0
) (
    input  sym_t a,
    output sym_t y
);
    // Constant multiply, reduced modulo the field polynomial.
    assign y = gf_mul(a, COEF);
endmodule

// File: rtl/rs_parity_lfsr.sv
// Division register producing the check symbols.
// Assumes absorb and shift are never high together, and that first is high
// only with the first absorbed byte of a packet.
module rs_parity_lfsr
    import rs204_pkg::*;
#(
    parameter int N_PARITY   = 16,
    parameter int FIRST_ROOT = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic absorb,
    input  logic first,
    input  logic shift,
    input  logic par_last,
    input  sym_t din,
    output sym_t par_top
);
    sym_t r    [N_PARITY];
    sym_t base [N_PARITY];
    sym_t prod [N_PARITY];
    sym_t fb;
    logic all_zero;

    // Treat the register as empty on the first byte of a packet.
    always_comb begin
        for (int i = 0; i < N_PARITY; i++) base[i] = first ? '0 : r[i];
    end

    assign fb = din ^ base[N_PARITY-1];

    genvar gi;
    generate
        for (gi = 0; gi < N_PARITY; gi++) begin : g_tap
            rs_gf_cmul #(.COEF(gen_coef(gi, N_PARITY, FIRST_ROOT))) u_mul (
                .a (fb),
                .y (prod[gi])
            );
        end
    endgenerate

    // Divide on message bytes; shift out with zero feedback on check bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PARITY; i++) r[i] <= '0;
        end else if (absorb) begin
            r[0] <= prod[0];
            for (int i = 1; i < N_PARITY; i++) r[i] <= base[i-1] ^ prod[i];
        end else if (shift) begin
            r[0] <= '0;
            for (int i = 1; i < N_PARITY; i++) r[i] <= r[i-1];
        end
    end

    assign par_top = r[N_PARITY-1];

    // Flag an all-zero register for the flush check.
    always_comb begin
        all_zero = 1'b1;
        for (int i = 0; i < N_PARITY; i++) if (r[i] != '0) all_zero = 1'b0;
    end

    // R8
    empty_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && par_last) |=> all_zero);
endmodule

// File: rtl/rs_enc_ctrl.sv
// Packet sequencer: counts message bytes, then check bytes, and drives both handshakes.
// Assumes the sink follows valid/ready rules; bytes at a boundary without sop are discarded.
module rs_enc_ctrl #(
    parameter int K_MSG    = 188,
    parameter int N_PARITY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sop,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic out_eop,
    output logic sel_parity,
    output logic absorb,
    output logic first,
    output logic shift,
    output logic par_last
);
    localparam int               LIMIT    = (K_MSG > N_PARITY) ? K_MSG : N_PARITY;
    localparam int               CNT_W    = $clog2(LIMIT);
    localparam logic [CNT_W-1:0] MSG_LAST = CNT_W'(K_MSG - 1);
    localparam logic [CNT_W-1:0] PAR_LAST = CNT_W'(N_PARITY - 1);

    typedef enum logic {PH_MSG, PH_PAR} phase_t;

    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic             skip;

    // Decode handshakes from the phase and the position in the packet.
    always_comb begin
        first      = (phase == PH_MSG) && (cnt == '0);
        skip       = first && !in_sop;
        sel_parity = (phase == PH_PAR);
        in_ready   = sel_parity ? 1'b0 : (skip ? 1'b1 : out_ready);
        out_valid  = sel_parity ? 1'b1 : (in_valid && !skip);
        absorb     = !sel_parity && in_valid && !skip && out_ready;
        shift      = sel_parity && out_ready;
        par_last   = sel_parity && (cnt == PAR_LAST);
        out_eop    = par_last;
    end

    // Advance the position counter and switch phase at each packet section end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_MSG;
            cnt   <= '0;
        end else if (absorb) begin
            if (cnt == MSG_LAST) begin
                phase <= PH_PAR;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (shift) begin
            if (par_last) begin
                phase <= PH_MSG;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2
    one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({absorb, shift}));

    // R4
    eop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> !out_eop);

    // R5
    parity_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |-> !in_ready);
endmodule

// File: rtl/rs204_encoder.sv
// Systematic encoder for the shortened RS(204,188) code.
// Assumes one byte per cycle at most. The message passes straight through, and
// 16 check bytes follow with the input held off.
module rs204_encoder #(
    parameter int K_MSG      = 188,
    parameter int N_PARITY   = 16,
    parameter int FIRST_ROOT = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic                        in_sop,
    input  logic [rs204_pkg::SYM_W-1:0] in_data,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [rs204_pkg::SYM_W-1:0] out_data,
    output logic                        out_eop
);
    import rs204_pkg::*;

    logic sel_parity;
    logic absorb;
    logic first;
    logic shift;
    logic par_last;
    sym_t par_top;

    rs_enc_ctrl #(.K_MSG(K_MSG), .N_PARITY(N_PARITY)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .out_ready  (out_ready),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_eop    (out_eop),
        .sel_parity (sel_parity),
        .absorb     (absorb),
        .first      (first),
        .shift      (shift),
        .par_last   (par_last)
    );

    rs_parity_lfsr #(.N_PARITY(N_PARITY), .FIRST_ROOT(FIRST_ROOT)) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .absorb   (absorb),
        .first    (first),
        .shift    (shift),
        .par_last (par_last),
        .din      (in_data),
        .par_top  (par_top)
    );

    // Select the message byte or the top check symbol.
    assign out_data = sel_parity ? par_top : in_data;

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && sel_parity) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/rs204_encoder_bench.sv
module rs204_encoder_bench;
    localparam int K  = 188;
    localparam int NP = 16;
    localparam int N  = K + NP;
    localparam int NPKT = K + 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_ready, in_sop;
    logic [7:0] in_data;
    logic       out_valid, out_ready, out_eop;
    logic [7:0] out_data;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;
    logic [7:0] gen [0:NP];

    always #5 clk = ~clk;

    rs204_encoder u_rs204_encoder (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_eop(out_eop)
    );

    function automatic logic [7:0] gfm(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
        end
        return acc;
    endfunction

    function automatic logic [7:0] msg_byte(input int p, input int i);
        if (p < K) return (i == p) ? 8'((p * 29) % 255 + 1) : 8'h00;
        if (p == K)     return 8'h00;
        if (p == K + 1) return 8'hFF;
        return 8'((p * 131 + i * 17 + i * i * 3) & 255) ^ 8'(p >> 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic present(input logic [7:0] d, input logic s);
        do begin
            @(negedge clk);
            in_valid = 1'b1; in_data = d; in_sop = s;
            #4;
        end while (!in_ready);
    endtask

    task automatic drive_all();
        for (int p = 0; p < NPKT; p++) begin
            if (p == K + 4) begin
                for (int jj = 0; jj < 3; jj++) present(8'hA5 + 8'(jj), 1'b0); // R7 junk
            end
            for (int i = 0; i < K; i++) begin
                if (p >= K + 2 && (i % 3) == 0) begin
                    @(negedge clk); in_valid = 1'b0; in_sop = 1'b0;
                end
                present(msg_byte(p, i), (i == 0) || (p == K + 5 && i == 60));
            end
        end
        @(negedge clk); in_valid = 1'b0; in_sop = 1'b0;
    endtask

    task automatic recv_all();
        logic [7:0] cw  [N];
        logic [7:0] rem [NP];
        logic [7:0] fb, s, aj, prev_data;
        bit prev_stall;
        int rc = 0;
        string req;
        for (int p = 0; p < NPKT; p++) begin
            for (int k = 0; k < NP; k++) rem[k] = 8'h00;
            for (int i = 0; i < K; i++) begin
                cw[i] = msg_byte(p, i);
                fb = cw[i] ^ rem[NP-1];
                for (int k = NP - 1; k >= 1; k--) rem[k] = rem[k-1] ^ gfm(gen[k], fb);
                rem[0] = gfm(gen[0], fb);
            end
            for (int k = 0; k < NP; k++) cw[K + k] = rem[NP - 1 - k];
            prev_stall = 0;
            prev_data  = 8'h00;
            for (int j = 0; j < N; j++) begin
                do begin
                    @(negedge clk);
                    out_ready = (p >= K + 3) ? ((rc % 5) < 3) : 1'b1;
                    rc++;
                    #4;
                    if (prev_stall) check(out_valid && out_data == prev_data, "R6", out_data, prev_data);
                    prev_stall = (j >= K) && out_valid && !out_ready;
                    prev_data  = out_data;
                end while (!(out_valid && out_ready));
                prev_stall = 0;
                req = (p >= K + 4) ? "R7" : ((j < K) ? "R2" : ((p < K) ? "R8" : "R3"));
                check(out_data == cw[j], req, out_data, cw[j]);
                check(out_eop == (j == N - 1), "R4", out_eop, (j == N - 1));
                if (j >= K) check(!in_ready, "R5", in_ready, 0);
            end
            aj = 8'h01;
            s  = 8'h00;
            for (int r = 0; r < NP; r++) begin
                logic [7:0] sy = 8'h00;
                for (int i = 0; i < N; i++) sy = gfm(sy, aj) ^ cw[i];
                s |= sy;
                aj = gfm(aj, 8'h02);
            end
            check(s == 8'h00, "R3", s, 0);
        end
        @(negedge clk); out_ready = 1'b0;
    endtask

    initial begin
        gen[0] = 8'h01;
        for (int k = 1; k <= NP; k++) gen[k] = 8'h00;
        begin
            logic [7:0] root = 8'h01;
            for (int i = 0; i < NP; i++) begin
                for (int k = NP; k >= 1; k--) gen[k] = gen[k-1] ^ gfm(gen[k], root);
                gen[0] = gfm(gen[0], root);
                root = gfm(root, 8'h02);
            end
        end
        rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_data = 8'h00; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        #4;
        check(!out_valid, "R1", out_valid, 0);
        check(!out_eop, "R1", out_eop, 0);
        check(in_ready, "R1", in_ready, 1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #4;
        check(!out_valid && in_ready, "R1", out_valid, 0);
        fork
            drive_all();
            recv_all();
        join
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule